// File: doc/BRIEF.md
# Reference Ratio Detector and Frequency Lock Monitor

This block sits beside a clock-recovery loop and decides whether the recovered clock runs at the right frequency. It receives one tick per cycle of the recovered clock after a fixed prescale, and one tick per cycle of an optional reference clock. The oscillator is expected at 16, 32 or 128 times the reference. The block counts recovered ticks across a gate of a fixed number of reference ticks and sorts each count to the nearest of the three expected values. The ratio it reports therefore comes from the reference itself and needs no setting.

A gate counts as in lock when its count lies inside a window around the expected value for its ratio and the previous gate sorted to the same ratio. The window is set as a parts-per-million tolerance. Loss of lock is reported on an active-low flag. While the loop is out of lock, a one-cycle reacquire request fires every few unlocked gates. A lock-to-reference request (active low) stops those retries and selects reference tracking when a reference is present. When no reference is present, the same request freezes the frequency control word that the block passes on.

Top module: `refratio_lock_mon`

## Requirements
- R1: While reset is high and on the first cycle after it, `lol_n` is 0, `ratio_sel` is 2'b00, `reacq_pulse` is 0 and `fcw_out` is 0.
- R2: At the end of each gate the count is sorted into a class. A count below the midpoint of the 16x and 32x expected counts is class 16 (code 2'b00). A count below the midpoint of the 32x and 128x expected counts is class 32 (code 2'b01). Any higher count is class 128 (code 2'b10). `ratio_sel` takes the new class only when two consecutive gates sort to it, and it never shows 2'b11.
- R3: A gate spans GATE_LEN reference ticks. It starts after the tick that ended the previous gate, or after the first tick that arms counting. Its count is the number of recovered ticks in the cycles after that starting tick, up to and including the cycle of its last tick. The expected count is GATE_LEN*ratio/REC_DIV. The window is expected*LOCK_PPM/1e6, rounded down. `lol_n` goes to 1 on the cycle after a gate whose count is within the window, inclusive, and whose class matches the previous gate.
- R4: After any gate with a count outside the window, or with a class that differs from the previous gate, `lol_n` is 0.
- R5: While unlocked with `ltr_n` high, `reacq_pulse` is high for one cycle at every REACQ_GATES-th consecutive unlocked gate result, so pulses are REACQ_GATES gate periods apart. No pulse occurs while locked.
- R6: A gate result taken while `ltr_n` is low produces no `reacq_pulse`.
- R7: `track_ref` is 1 exactly when `ref_present` is 1 and `ltr_n` is 0, with no delay.
- R8: `fcw_out` copies `fcw_in` one cycle later. When `ltr_n` is 0 and `ref_present` is 0 at a clock edge, `fcw_out` keeps its value instead.
- R9: When `ref_present` is 0, `lol_n` is 0 on the next cycle and `ratio_sel` holds. After the reference returns, the first reference tick only arms counting, so lock comes back no sooner than the end of the second full gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_tick | input | 1 | One-cycle pulse per prescaled recovered-clock period |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| ref_present | input | 1 | High when a reference clock is supplied |
| ltr_n | input | 1 | Lock-to-reference request, active low |
| fcw_in | input | FCW_W | Frequency control word from the loop filter |
| ratio_sel | output | 2 | Detected ratio: 00=16, 01=32, 10=128 |
| lol_n | output | 1 | Loss of lock, low when unlocked |
| reacq_pulse | output | 1 | One-cycle reacquire request |
| track_ref | output | 1 | 1 selects reference tracking, 0 selects data tracking |
| fcw_out | output | FCW_W | Control word passed on, frozen while held |

## Verification
A gate counter that is off by a single tick shifts every measured count. The fault then appears at the exact inclusive edges of the lock windows, so counts one inside and one outside each window are driven for all three ratios. A wrong class threshold or a stale previous-class register shows in `ratio_sel` within two gate periods. A miscounting unlocked-gate counter shows as a reacquire interval other than REACQ_GATES gate periods. A hold path that leaks shows in `fcw_out` one cycle after the new word is applied.

// File: rtl/refratio_lock_mon.sv
module refratio_lock_mon #(
  parameter int GATE_LEN    = 4096,
  parameter int REC_DIV     = 16,
  parameter int LOCK_PPM    = 650,
  parameter int REACQ_GATES = 8,
  parameter int FCW_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_tick,
  input  logic             ref_tick,
  input  logic             ref_present,
  input  logic             ltr_n,
  input  logic [FCW_W-1:0] fcw_in,
  output logic [1:0]       ratio_sel,
  output logic             lol_n,
  output logic             reacq_pulse,
  output logic             track_ref,
  output logic [FCW_W-1:0] fcw_out
);
  localparam longint EXP0 = longint'(GATE_LEN) * 16 / REC_DIV;
  localparam longint EXP1 = longint'(GATE_LEN) * 32 / REC_DIV;
  localparam longint EXP2 = longint'(GATE_LEN) * 128 / REC_DIV;
  localparam longint WIN0 = EXP0 * LOCK_PPM / 1000000;
  localparam longint WIN1 = EXP1 * LOCK_PPM / 1000000;
  localparam longint WIN2 = EXP2 * LOCK_PPM / 1000000;
  localparam int CNT_W   = $clog2(EXP2 * 4);
  localparam int GATE_W  = $clog2(GATE_LEN + 1);
  localparam int REACQ_W = $clog2(REACQ_GATES + 1);
  localparam logic [CNT_W:0] TH01 = (CNT_W+1)'((EXP0 + EXP1) / 2);
  localparam logic [CNT_W:0] TH12 = (CNT_W+1)'((EXP1 + EXP2) / 2);
  localparam logic [CNT_W:0] LO0 = (CNT_W+1)'(EXP0 - WIN0);
  localparam logic [CNT_W:0] HI0 = (CNT_W+1)'(EXP0 + WIN0);
  localparam logic [CNT_W:0] LO1 = (CNT_W+1)'(EXP1 - WIN1);
  localparam logic [CNT_W:0] HI1 = (CNT_W+1)'(EXP1 + WIN1);
  localparam logic [CNT_W:0] LO2 = (CNT_W+1)'(EXP2 - WIN2);
  localparam logic [CNT_W:0] HI2 = (CNT_W+1)'(EXP2 + WIN2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              armed;
  logic [GATE_W-1:0] ref_cnt;
  logic [CNT_W-1:0]  rec_cnt;
  logic [1:0]        prev_cls, ratio_q, cls;
  logic              prev_vld, lol_q, reacq_q;
  logic [REACQ_W-1:0] miss_cnt;
  logic [FCW_W-1:0]  fcw_q;
  logic [CNT_W:0]    meas, lo, hi;
  logic              gate_end, agree, good;

  assign gate_end = ref_present && armed && ref_tick && (ref_cnt == GATE_W'(GATE_LEN - 1));
  assign meas     = {1'b0, rec_cnt} + (CNT_W+1)'(rec_tick);

  always_comb begin
    if (meas < TH01)      cls = 2'd0;
    else if (meas < TH12) cls = 2'd1;
    else                  cls = 2'd2;
    case (cls)
      2'd0:    begin lo = LO0; hi = HI0; end
      2'd1:    begin lo = LO1; hi = HI1; end
      default: begin lo = LO2; hi = HI2; end
    endcase
  end

  assign agree = prev_vld && (prev_cls == cls);
  assign good  = agree && (meas >= lo) && (meas <= hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      ref_cnt  <= '0;
      rec_cnt  <= '0;
      prev_cls <= 2'd0;
      prev_vld <= 1'b0;
      ratio_q  <= 2'd0;
      lol_q    <= 1'b0;
      reacq_q  <= 1'b0;
      miss_cnt <= '0;
    end else if (!ref_present) begin
      armed    <= 1'b0;
      ref_cnt  <= '0;
      rec_cnt  <= '0;
      prev_vld <= 1'b0;
      lol_q    <= 1'b0;
      reacq_q  <= 1'b0;
      miss_cnt <= '0;
    end else begin
      reacq_q <= 1'b0;
      if (!armed) begin
        if (ref_tick) begin
          armed   <= 1'b1;
          ref_cnt <= '0;
          rec_cnt <= '0;
        end
      end else begin
        if (gate_end)
          rec_cnt <= '0;
        else if (rec_tick && rec_cnt != CNT_MAX)
          rec_cnt <= rec_cnt + 1'b1;
        if (ref_tick)
          ref_cnt <= gate_end ? '0 : ref_cnt + 1'b1;
      end
      if (gate_end) begin
        prev_cls <= cls;
        prev_vld <= 1'b1;
        if (agree) ratio_q <= cls;
        lol_q <= good;
        if (good) begin
          miss_cnt <= '0;
        end else if (ltr_n) begin
          if (miss_cnt == REACQ_W'(REACQ_GATES - 1)) begin
            miss_cnt <= '0;
            reacq_q  <= 1'b1;
          end else begin
            miss_cnt <= miss_cnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        fcw_q <= '0;
    else if (ltr_n || ref_present)  fcw_q <= fcw_in;
  end

  assign ratio_sel   = ratio_q;
  assign lol_n       = lol_q;
  assign reacq_pulse = reacq_q;
  assign track_ref   = ref_present && !ltr_n;
  assign fcw_out     = fcw_q;
endmodule

module refratio_lock_mon_chk #(
  parameter int FCW_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_present,
  input logic             ltr_n,
  input logic [1:0]       ratio_sel,
  input logic             lol_n,
  input logic             reacq_pulse,
  input logic [FCW_W-1:0] fcw_out
);
  assert_ratio_code_R2: assert property (@(posedge clk) disable iff (rst)
    ratio_sel != 2'b11);
  assert_lock_needs_ref_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(lol_n) |-> $past(ref_present));
  assert_reacq_unlocked_R5: assert property (@(posedge clk) disable iff (rst)
    reacq_pulse |-> !lol_n);
  assert_reacq_single_R5: assert property (@(posedge clk) disable iff (rst)
    reacq_pulse |=> !reacq_pulse);
  assert_reacq_no_ltr_R6: assert property (@(posedge clk) disable iff (rst)
    reacq_pulse |-> $past(ltr_n));
  assert_fcw_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!ltr_n && !ref_present) |=> $stable(fcw_out));
  assert_absent_unlock_R9: assert property (@(posedge clk) disable iff (rst)
    !ref_present |=> !lol_n);
endmodule

bind refratio_lock_mon refratio_lock_mon_chk #(.FCW_W(FCW_W)) u_chk (
  .clk(clk), .rst(rst), .ref_present(ref_present), .ltr_n(ltr_n),
  .ratio_sel(ratio_sel), .lol_n(lol_n), .reacq_pulse(reacq_pulse),
  .fcw_out(fcw_out)
);

// File: tb/refratio_lock_mon_tb.sv
module refratio_lock_mon_tb;
  localparam int GATE_CYC = 512;
  localparam int NVEC = 17;
  localparam logic [12:0] VEC [NVEC] = '{
    {10'd64, 2'd0, 1'b1}, {10'd67, 2'd0, 1'b1}, {10'd68, 2'd0, 1'b0},
    {10'd61, 2'd0, 1'b1}, {10'd60, 2'd0, 1'b0}, {10'd95, 2'd0, 1'b0},
    {10'd96, 2'd1, 1'b0}, {10'd128, 2'd1, 1'b1}, {10'd134, 2'd1, 1'b1},
    {10'd135, 2'd1, 1'b0}, {10'd122, 2'd1, 1'b1}, {10'd200, 2'd1, 1'b0},
    {10'd319, 2'd1, 1'b0}, {10'd320, 2'd2, 1'b0}, {10'd512, 2'd2, 1'b1},
    {10'd487, 2'd2, 1'b1}, {10'd486, 2'd2, 1'b0}
  };

  logic clk = 0, rst = 1;
  logic rec_tick = 0, ref_tick = 0, ref_present = 1, ltr_n = 1;
  logic [15:0] fcw_in = 0;
  logic [1:0] ratio_sel;
  logic lol_n, reacq_pulse, track_ref;
  logic [15:0] fcw_out;

  int checks = 0, failures = 0, cyc = 0, pulses = 0, last_pulse = 0, gap = 0;
  int rec_num = 64, acc = 0, ref_ph = 0;
  bit ticks_on = 0, done = 0;

  refratio_lock_mon #(.GATE_LEN(64), .REC_DIV(16), .LOCK_PPM(50000),
                      .REACQ_GATES(2), .FCW_W(16)) u_dut (
    .clk(clk), .rst(rst), .rec_tick(rec_tick), .ref_tick(ref_tick),
    .ref_present(ref_present), .ltr_n(ltr_n), .fcw_in(fcw_in),
    .ratio_sel(ratio_sel), .lol_n(lol_n), .reacq_pulse(reacq_pulse),
    .track_ref(track_ref), .fcw_out(fcw_out));

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (reacq_pulse) begin
      pulses++;
      gap = cyc - last_pulse;
      last_pulse = cyc;
    end
    if (ticks_on) begin
      ref_tick = (ref_ph == 0);
      ref_ph = (ref_ph + 1) % 8;
      acc += rec_num;
      if (acc >= GATE_CYC) begin rec_tick = 1; acc -= GATE_CYC; end
      else rec_tick = 0;
    end else begin
      ref_tick = 0;
      rec_tick = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    wait_cyc(3);
    chk("R1 lol_n", lol_n, 0);
    chk("R1 ratio_sel", ratio_sel, 0);
    chk("R1 reacq", reacq_pulse, 0);
    chk("R1 fcw_out", fcw_out, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 lol_n after release", lol_n, 0);
    ticks_on = 1;

    for (int i = 0; i < NVEC; i++) begin
      rec_num = int'(VEC[i][12:3]);
      wait_cyc(3 * GATE_CYC + 16);
      chk($sformatf("R2 ratio num=%0d", rec_num), ratio_sel, VEC[i][2:1]);
      chk($sformatf("R3 R4 lock num=%0d", rec_num), lol_n, VEC[i][0]);
    end

    rec_num = 200;
    wait_cyc(3 * GATE_CYC);
    pulses = 0;
    wait_cyc(5 * GATE_CYC);
    chk("R5 pulses while unlocked", pulses >= 2, 1);
    chk("R5 pulse spacing", gap, 2 * GATE_CYC);

    rec_num = 64;
    wait_cyc(3 * GATE_CYC);
    pulses = 0;
    wait_cyc(4 * GATE_CYC);
    chk("R5 no pulse while locked", pulses, 0);
    chk("R5 locked", lol_n, 1);

    ltr_n = 0;
    rec_num = 200;
    @(negedge clk);
    chk("R7 track_ref ref present ltr low", track_ref, 1);
    pulses = 0;
    wait_cyc(6 * GATE_CYC);
    chk("R6 no pulse under ltr", pulses, 0);
    chk("R6 unlocked under ltr", lol_n, 0);
    ltr_n = 1;
    #1;
    chk("R7 track_ref ltr high", track_ref, 0);

    rec_num = 128;
    wait_cyc(3 * GATE_CYC + 16);
    chk("R2 ratio before absence", ratio_sel, 1);
    chk("R3 locked before absence", lol_n, 1);
    ticks_on = 0;
    ref_present = 0;
    @(negedge clk);
    chk("R9 unlock on absence", lol_n, 0);
    wait_cyc(20);
    chk("R9 ratio held", ratio_sel, 1);
    ticks_on = 1;
    ref_present = 1;
    wait_cyc(700);
    chk("R9 no lock after one gate", lol_n, 0);
    wait_cyc(400);
    chk("R9 lock after second gate", lol_n, 1);

    fcw_in = 16'h1234;
    @(negedge clk);
    chk("R8 follow", fcw_out, 16'h1234);
    ticks_on = 0;
    ref_present = 0;
    ltr_n = 0;
    fcw_in = 16'hBEEF;
    #1;
    chk("R7 track_ref no ref", track_ref, 0);
    wait_cyc(5);
    chk("R8 hold", fcw_out, 16'h1234);
    ltr_n = 1;
    @(negedge clk);
    chk("R8 release", fcw_out, 16'hBEEF);
    ref_present = 1;
    ltr_n = 0;
    fcw_in = 16'h0F0F;
    @(negedge clk);
    chk("R8 ltr with ref follows", fcw_out, 16'h0F0F);
    finish_run();
  end
endmodule